// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block holds a bank of general-purpose pins that software controls through a plain memory-mapped register bus. The bus has an address, a write enable, write data and combinational read data. Each pin can be set as an input or an output and has an output value register. It also reads back its pad level through a two-flop synchroniser. Each pin watches its synchronised level for an interrupt event. The event is either a level or an edge, and it can be active high or active low.

Detected events are latched in a per-pin status bit, which software clears by writing 1. A per-pin routing register decides whether a pin's latched status may reach the processor. A single summary interrupt line combines every pin that is enabled, routed to the processor and has status pending.

The detector has no native both-edges mode. Software gets one by inverting the polarity bit after each event. The detector therefore always uses the current polarity for the next comparison.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every pin is an input (pad output enable low), every interrupt configuration field and status bit reads 0, every routing register reads 7, and the summary line is low.
- R2: Pin p's configuration register sits at byte address 0x1000 + 16*p. Bit 9 drives the pin's pad output enable (0 = input). Pin p's value register at 0x1000 + 16*p + 4 stores bit 1 as the driven output value. Both read back.
- R3: Bit 0 of the value register returns the pad level after two-flop synchronisation. A pad change appears there after the second rising clock edge, and not after the first.
- R4: Interrupt configuration at 0x1000 + 16*p + 8 has these fields: bit 0 enable, bit 1 polarity (1 = rising/high), bit 2 detect mode (1 = edge, 0 = level), bit 3 raw-status enable. In edge mode only the transition selected by the polarity bit sets status. The opposite transition does not.
- R5: In level mode, status is set while the synchronised input equals the polarity bit. A clear during that time is overridden, and status reads 1 again.
- R6: Status bit 0 at 0x1000 + 16*p + 12 is cleared by writing 1. Writing 0 leaves it unchanged.
- R7: When the raw-status enable bit is 0, no event is recorded in status.
- R8: The summary line is high exactly when some pin has status 1, enable bit 1 and routing value 4. Routing value 7, or enable 0, keeps a set status off the line.
- R9: A polarity change takes effect at the next detection. After a rising-edge event is cleared, setting polarity to 0 lets the following falling edge set status.
- R10: Pin p's routing register sits at 0x400 + 4*p. Addresses outside the pin and routing windows, or naming a pin index at or beyond the pin count, read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| padIn | input | NUM_PINS | Asynchronous pad levels |
| padOe | output | NUM_PINS | Pad output enables |
| padOut | output | NUM_PINS | Pad output values |
| summaryIrq | output | 1 | Combined interrupt to the processor |

## Verification
The assertions assume that bus writes arrive as single-cycle strobes with stable address and data around the sampling edge. They also assume that padIn needs two edges to appear at the synchroniser output, which holds only when pad changes happen away from the clock edge. The bench drives every pad and bus input on the falling edge and holds each write for exactly one rising edge. It waits at least four cycles after each pad change before it reads status, so the synchroniser and the status register have settled at the sample point.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned OE_BIT       = 9;
  localparam int unsigned IO_IN_BIT    = 0;
  localparam int unsigned IO_OUT_BIT   = 1;
  localparam int unsigned IC_EN        = 0;
  localparam int unsigned IC_POL       = 1;
  localparam int unsigned IC_EDGE      = 2;
  localparam int unsigned IC_RAW       = 3;
  localparam int unsigned ICFG_W       = 4;
  localparam int unsigned ROUTE_W      = 3;
  localparam logic [2:0]  ROUTE_CPU    = 3'd4;
  localparam logic [2:0]  ROUTE_OFF    = 3'd7;
  localparam int unsigned PIN_BASE     = 32'h1000;
  localparam int unsigned PIN_STRIDE   = 16;
  localparam int unsigned ROUTE_BASE   = 32'h0400;
  localparam int unsigned ROUTE_STRIDE = 4;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CFG,
    RD_IO,
    RD_ICFG,
    RD_STAT,
    RD_ROUTE
  } regKind_e;

  typedef struct packed {
    logic     wrCfg;
    logic     wrIo;
    logic     wrIcfg;
    logic     wrStat;
    logic     wrRoute;
    regKind_e kind;
  } busCmd_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 16,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busCmd_t           cmd,
  output logic [IDX_W-1:0]  pinSel
);

  localparam int unsigned PIN_END   = PIN_BASE + NUM_PINS * PIN_STRIDE;
  localparam int unsigned ROUTE_END = ROUTE_BASE + NUM_PINS * ROUTE_STRIDE;

  logic [31:0] addr32;
  logic [31:0] pinOff;
  logic [31:0] routeOff;
  regKind_e    kind;

  assign addr32   = 32'(busAddr);
  assign pinOff   = addr32 - PIN_BASE;
  assign routeOff = addr32 - ROUTE_BASE;

  always_comb begin
    kind   = RD_NONE;
    pinSel = '0;
    if (addr32[1:0] == 2'b00) begin
      if (addr32 >= PIN_BASE && addr32 < PIN_END) begin
        pinSel = IDX_W'(pinOff / PIN_STRIDE);
        unique case (pinOff[3:2])
          2'd0: kind = RD_CFG;
          2'd1: kind = RD_IO;
          2'd2: kind = RD_ICFG;
          default: kind = RD_STAT;
        endcase
      end else if (addr32 >= ROUTE_BASE && addr32 < ROUTE_END) begin
        pinSel = IDX_W'(routeOff / ROUTE_STRIDE);
        kind   = RD_ROUTE;
      end
    end
  end

  always_comb begin
    cmd         = '0;
    cmd.kind    = kind;
    cmd.wrCfg   = busWe && (kind == RD_CFG);
    cmd.wrIo    = busWe && (kind == RD_IO);
    cmd.wrIcfg  = busWe && (kind == RD_ICFG);
    cmd.wrStat  = busWe && (kind == RD_STAT);
    cmd.wrRoute = busWe && (kind == RD_ROUTE);
  end

endmodule

// File: rtl/gpio_pin_event.sv
module gpio_pin_event (
  input  logic clk,
  input  logic rstN,
  input  logic padRaw,
  input  logic activeHigh,
  input  logic edgeMode,
  output logic level,
  output logic evtHit
);

  logic syncA;
  logic syncB;
  logic lastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      lastQ <= 1'b0;
    end else begin
      syncA <= padRaw;
      syncB <= syncA;
      lastQ <= syncB;
    end
  end

  assign level = syncB;

  always_comb begin
    if (edgeMode) begin
      evtHit = activeHigh ? (syncB && !lastQ) : (!syncB && lastQ);
    end else begin
      evtHit = (syncB == activeHigh);
    end
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  busCmd_t             cmd,
  input  logic [IDX_W-1:0]    pinSel,
  input  logic [31:0]         wdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [31:0]         rdata,
  output logic                summaryIrq,
  output logic [NUM_PINS-1:0] statVec,
  output logic [NUM_PINS-1:0] rawEnVec,
  output logic [NUM_PINS-1:0] syncVec
);

  logic [NUM_PINS-1:0] oeQ;
  logic [NUM_PINS-1:0] outQ;
  logic [NUM_PINS-1:0] statQ;
  logic [NUM_PINS-1:0] evtVec;
  logic [NUM_PINS-1:0] levelVec;
  logic [NUM_PINS-1:0] selVec;
  logic [NUM_PINS-1:0] liveVec;
  logic [ICFG_W-1:0]   icfgQ  [NUM_PINS];
  logic [ROUTE_W-1:0]  routeQ [NUM_PINS];

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    gpio_pin_event u_evt (
      .clk       (clk),
      .rstN      (rstN),
      .padRaw    (padIn[g]),
      .activeHigh(icfgQ[g][IC_POL]),
      .edgeMode  (icfgQ[g][IC_EDGE]),
      .level     (levelVec[g]),
      .evtHit    (evtVec[g])
    );
    assign selVec[g]   = (pinSel == IDX_W'(g));
    assign rawEnVec[g] = icfgQ[g][IC_RAW];
    assign liveVec[g]  = statQ[g] && icfgQ[g][IC_EN] && (routeQ[g] == ROUTE_CPU);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeQ   <= '0;
      outQ  <= '0;
      statQ <= '0;
      for (int i = 0; i < NUM_PINS; i++) begin
        icfgQ[i]  <= '0;
        routeQ[i] <= ROUTE_OFF;
      end
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (cmd.wrCfg && selVec[i])   oeQ[i]    <= wdata[OE_BIT];
        if (cmd.wrIo && selVec[i])    outQ[i]   <= wdata[IO_OUT_BIT];
        if (cmd.wrIcfg && selVec[i])  icfgQ[i]  <= wdata[ICFG_W-1:0];
        if (cmd.wrRoute && selVec[i]) routeQ[i] <= wdata[ROUTE_W-1:0];
        statQ[i] <= (statQ[i] && !(cmd.wrStat && selVec[i] && wdata[0]))
                    || (evtVec[i] && icfgQ[i][IC_RAW]);
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (cmd.kind)
      RD_CFG:   rdata[OE_BIT] = oeQ[pinSel];
      RD_IO: begin
        rdata[IO_IN_BIT]  = levelVec[pinSel];
        rdata[IO_OUT_BIT] = outQ[pinSel];
      end
      RD_ICFG:  rdata[ICFG_W-1:0]  = icfgQ[pinSel];
      RD_STAT:  rdata[0]           = statQ[pinSel];
      RD_ROUTE: rdata[ROUTE_W-1:0] = routeQ[pinSel];
      default:  rdata = '0;
    endcase
  end

  assign padOe      = oeQ;
  assign padOut     = outQ;
  assign summaryIrq = |liveVec;
  assign statVec    = statQ;
  assign syncVec    = levelVec;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 16,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic                summaryIrq
);

  busCmd_t             cmd;
  logic [IDX_W-1:0]    pinSel;
  logic [NUM_PINS-1:0] statVec;
  logic [NUM_PINS-1:0] rawEnVec;
  logic [NUM_PINS-1:0] syncVec;

  gpio_bank_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr),
    .busWe  (busWe),
    .cmd    (cmd),
    .pinSel (pinSel)
  );

  gpio_bank_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .pinSel    (pinSel),
    .wdata     (busWdata),
    .padIn     (padIn),
    .padOe     (padOe),
    .padOut    (padOut),
    .rdata     (busRdata),
    .summaryIrq(summaryIrq),
    .statVec   (statVec),
    .rawEnVec  (rawEnVec),
    .syncVec   (syncVec)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWe,
  input logic [31:0]         busWdata,
  input logic [NUM_PINS-1:0] padIn,
  input logic [NUM_PINS-1:0] padOe,
  input logic                summaryIrq,
  input logic [NUM_PINS-1:0] statVec,
  input logic [NUM_PINS-1:0] rawEnVec,
  input logic [NUM_PINS-1:0] syncVec
);

  logic [1:0] warmCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_idle_R1: assert (summaryIrq == 1'b0 && padOe == '0);
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    assert_oe_write_R2: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && 32'(busAddr) == 32'h1000 + 32'(g) * 16)
        |=> (padOe[g] == $past(busWdata[9])));

    assert_raw_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
      !rawEnVec[g] |=> !$rose(statVec[g]));
  end

  assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt >= 2'd2) |-> (syncVec == $past(padIn, 2)));

  assert_summary_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    summaryIrq |-> (statVec != '0));

endmodule

bind gpio_irq_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWe     (busWe),
  .busWdata  (busWdata),
  .padIn     (padIn),
  .padOe     (padOe),
  .summaryIrq(summaryIrq),
  .statVec   (statVec),
  .rawEnVec  (rawEnVec),
  .syncVec   (syncVec)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;

  localparam int NUM_PINS = 8;
  localparam int ADDR_W   = 16;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [ADDR_W-1:0]   busAddr = '0;
  logic                busWe = 1'b0;
  logic [31:0]         busWdata = '0;
  logic [31:0]         busRdata;
  logic [NUM_PINS-1:0] padIn = '0;
  logic [NUM_PINS-1:0] padOe;
  logic [NUM_PINS-1:0] padOut;
  logic                summaryIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .summaryIrq(summaryIrq)
  );

  function automatic logic [ADDR_W-1:0] regAddr(int pin, int slot);
    return ADDR_W'(32'h1000 + pin * 16 + slot * 4);
  endfunction

  function automatic logic [ADDR_W-1:0] routeAddr(int pin);
    return ADDR_W'(32'h400 + pin * 4);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(logic [ADDR_W-1:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPad(int pin, logic v);
    @(negedge clk);
    padIn[pin] = v;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);

    // R1: reset values of every pin
    for (int p = 0; p < NUM_PINS; p++) begin
      busRead(regAddr(p, 0), rd); check("R1 cfg", rd, 0);
      busRead(regAddr(p, 2), rd); check("R1 icfg", rd, 0);
      busRead(regAddr(p, 3), rd); check("R1 stat", rd, 0);
      busRead(routeAddr(p), rd);  check("R1 route", rd, 7);
    end
    check("R1 padOe", 32'(padOe), 0);
    check("R1 summary", 32'(summaryIrq), 0);

    // R10: unmapped windows read zero and ignore writes
    busRead(regAddr(NUM_PINS, 0), rd); check("R10 pin beyond count", rd, 0);
    busRead(routeAddr(NUM_PINS), rd); check("R10 route beyond count", rd, 0);
    busRead(ADDR_W'(16'h0000), rd); check("R10 low hole", rd, 0);
    busRead(ADDR_W'(16'h1001), rd); check("R10 unaligned", rd, 0);
    busWrite(regAddr(NUM_PINS, 0), 32'h200);
    busWrite(ADDR_W'(16'h1001), 32'hFFFF_FFFF);
    check("R10 no oe change", 32'(padOe), 0);
    busRead(regAddr(0, 0), rd); check("R10 pin0 cfg untouched", rd, 0);

    // R3: synchroniser latency on pin 0
    @(negedge clk); padIn[0] = 1'b1;
    @(negedge clk); busRead(regAddr(0, 1), rd); check("R3 after one edge", rd & 1, 0);
    @(negedge clk); busRead(regAddr(0, 1), rd); check("R3 after two edges", rd & 1, 1);
    setPad(0, 1'b0);
    waitClk(3);

    for (int p = 0; p < NUM_PINS; p++) begin
      // R2: output enable and output value
      busWrite(regAddr(p, 0), 32'h200);
      check("R2 padOe", 32'(padOe), 32'(1) << p);
      busRead(regAddr(p, 0), rd); check("R2 cfg readback", rd, 32'h200);
      busWrite(regAddr(p, 1), 32'h2);
      check("R2 padOut", 32'(padOut), 32'(1) << p);
      busRead(regAddr(p, 1), rd); check("R2 io readback", rd & 2, 2);
      busWrite(regAddr(p, 0), 0);
      busWrite(regAddr(p, 1), 0);
      check("R2 cleared", 32'(padOe | padOut), 0);

      for (int pol = 0; pol < 2; pol++) begin
        logic [31:0] edgeCfg;
        edgeCfg = 32'h1 | (32'(pol) << 1) | 32'h4 | 32'h8;
        setPad(p, pol[0]);
        waitClk(4);
        busWrite(regAddr(p, 2), edgeCfg);
        busWrite(routeAddr(p), 4);
        busWrite(regAddr(p, 3), 1);
        setPad(p, !pol[0]);
        waitClk(4);
        busRead(regAddr(p, 3), rd); check("R4 wrong edge ignored", rd, 0);
        check("R8 summary idle", 32'(summaryIrq), 0);
        setPad(p, pol[0]);
        waitClk(4);
        busRead(regAddr(p, 3), rd); check("R4 active edge", rd, 1);
        check("R8 summary raised", 32'(summaryIrq), 1);
        busWrite(routeAddr(p), 7);
        check("R8 route off blocks", 32'(summaryIrq), 0);
        busWrite(routeAddr(p), 4);
        check("R8 route cpu passes", 32'(summaryIrq), 1);
        busWrite(regAddr(p, 2), edgeCfg & ~32'h1);
        check("R8 enable off blocks", 32'(summaryIrq), 0);
        busRead(regAddr(p, 3), rd); check("R8 status kept", rd, 1);
        busWrite(regAddr(p, 3), 0);
        busRead(regAddr(p, 3), rd); check("R6 write zero keeps", rd, 1);
        busWrite(regAddr(p, 3), 1);
        busRead(regAddr(p, 3), rd); check("R6 write one clears", rd, 0);

        // R5: level mode with the pad held active
        busWrite(regAddr(p, 2), 32'h1 | (32'(pol) << 1) | 32'h8);
        waitClk(2);
        busRead(regAddr(p, 3), rd); check("R5 level sets", rd, 1);
        busWrite(regAddr(p, 3), 1);
        busRead(regAddr(p, 3), rd); check("R5 level re-sets", rd, 1);
        setPad(p, !pol[0]);
        waitClk(4);
        busWrite(regAddr(p, 3), 1);
        waitClk(2);
        busRead(regAddr(p, 3), rd); check("R5 inactive stays clear", rd, 0);

        // R7: raw-status enable off
        busWrite(regAddr(p, 2), 32'h1 | (32'(pol) << 1) | 32'h4);
        setPad(p, pol[0]);
        waitClk(4);
        busRead(regAddr(p, 3), rd); check("R7 no record", rd, 0);
        check("R7 summary low", 32'(summaryIrq), 0);

        busWrite(regAddr(p, 2), 0);
        busWrite(routeAddr(p), 7);
        busWrite(regAddr(p, 3), 1);
      end

      // R9: polarity flip emulating both edges
      setPad(p, 1'b0);
      waitClk(4);
      busWrite(regAddr(p, 2), 32'hF);
      busWrite(regAddr(p, 3), 1);
      setPad(p, 1'b1);
      waitClk(4);
      busRead(regAddr(p, 3), rd); check("R9 rising first", rd, 1);
      busWrite(regAddr(p, 3), 1);
      busWrite(regAddr(p, 2), 32'hD);
      busRead(regAddr(p, 3), rd); check("R9 cleared before fall", rd, 0);
      setPad(p, 1'b0);
      waitClk(4);
      busRead(regAddr(p, 3), rd); check("R9 falling after flip", rd, 1);
      busWrite(regAddr(p, 2), 0);
      busWrite(regAddr(p, 3), 1);
      busRead(regAddr(p, 3), rd); check("R6 final clear", rd, 0);
    end

    check("R8 summary quiet at end", 32'(summaryIrq), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule